// File: doc/BRIEF.md
# Fiber Far-End Fault Signaler

This block raises and recognises the far-end fault indication on a 100 Mbps optical link, one serial bit per clock. On the send side it watches the signal-detect input from the optical transceiver. When receive signal quality is lost, it replaces the normal outgoing bit stream with a repeating fault pattern. Each pattern unit is a run of 84 one bits closed by a single zero bit, so one unit is 85 bits long.

On the receive side it scans the incoming serial bits for the same unit. It raises a remote-fault flag once three valid units have arrived back to back. It also reports link failure whenever signal detect is low in fiber mode.

In twisted-pair mode the whole function is inactive and the outgoing bit simply follows the normal transmit bit. Line coding, the optics and auto-negotiation are handled elsewhere.

Top module: `ffs_signaler`

## Requirements
- R1: While reset is high, and on the first sample after it is released, `tx_bit`, `pattern_active`, `link_fail` and `remote_fault` are all 0.
- R2: With `fiber_mode` low, `tx_bit` equals `tx_norm_bit` from the previous clock edge. In that mode `pattern_active`, `link_fail` and `remote_fault` stay 0, whatever the signal detect or the received bits.
- R3: A fault starts when the block is idle and a clock edge sees all of the following: `fiber_mode` 1, `fault_tx_en` 1, `loopback` 0 and `sig_det` 0. From that edge, `pattern_active` is 1 and `tx_bit` sends units of 84 ones followed by one zero, one bit per clock.
- R4: Once started, the pattern goes out at least three complete units (255 bits), even if signal detect comes back during the first unit.
- R5: After three units, the pattern keeps repeating while the fault condition holds. Once the condition has cleared, `pattern_active` falls and `tx_bit` returns to `tx_norm_bit` at the first unit boundary.
- R6: With `fault_tx_en` 0, a loss of signal never starts the pattern, and `tx_bit` keeps following `tx_norm_bit`.
- R7: With `loopback` 1, a loss of signal never starts the pattern. Clearing `loopback` while the loss persists starts the pattern at the next edge.
- R8: `link_fail` is a register. Each clock edge loads it with (`fiber_mode` AND NOT `sig_det`).
- R9: `remote_fault` rises at the edge that takes in the zero ending the third consecutive valid unit. A valid unit is exactly 84 ones followed by a zero. The flag stays high while further valid units follow.
- R10: An invalid window clears the detector's unit count and `remote_fault` at the edge that takes in the offending bit. An invalid window is either a zero after any run length other than 84, or an 85th consecutive one.
- R11: While `sig_det` is 0 or `fiber_mode` is 0, the detector is blocked. Its counts and `remote_fault` clear at the next edge, and received patterns cannot set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fiber_mode | input | 1 | 1 selects the optical link function |
| fault_tx_en | input | 1 | Permits sending the fault pattern |
| loopback | input | 1 | Loopback active; blocks fault sending |
| sig_det | input | 1 | Signal detect from the optical transceiver |
| rx_bit | input | 1 | Received serial bit |
| tx_norm_bit | input | 1 | Normal outgoing serial bit |
| tx_bit | output | 1 | Outgoing serial bit (registered) |
| pattern_active | output | 1 | Fault pattern is being sent |
| link_fail | output | 1 | Signal loss in fiber mode |
| remote_fault | output | 1 | Far end is sending the fault pattern |

## Verification
The bench restores signal detect one bit into the first unit. A sender that did not enforce the minimum of three units would fall idle after 85 or 170 bits instead of 255.

It also restores the signal in the middle of the fourth unit. A sender that stopped at once, rather than at the unit boundary, would cut the unit short, and a wrong bit count would put the zero in the wrong place.

On the receive side it feeds a run of 83 ones, a run of 85 ones and a signal loss while the flag is high. A detector that tolerated off-by-one runs, or ignored the loss, would leave `remote_fault` set. A detector that needed the wrong number of repeats would change the flag one unit early or late.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  localparam int FFS_ONES_DEFAULT = 84;
  localparam int FFS_REPS_DEFAULT = 3;

  typedef enum logic {
    TX_NORMAL = 1'b0,
    TX_FAULT  = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/ffs_link_mon.sv
module ffs_link_mon (
  input  logic clk,
  input  logic rst,
  input  logic fiber_mode,
  input  logic sig_det,
  output logic scan_en,
  output logic link_fail
);
  logic link_fail_q;

  assign scan_en   = fiber_mode & sig_det;
  assign link_fail = link_fail_q;

  always_ff @(posedge clk) begin
    if (rst) link_fail_q <= 1'b0;
    else     link_fail_q <= fiber_mode & ~sig_det;
  end

  // R8: a rising link_fail needs a loss of signal on the edge before
  p_link_fail_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(link_fail) |-> ($past(fiber_mode) && !$past(sig_det)));
endmodule

// File: rtl/ffs_tx_gen.sv
module ffs_tx_gen
  import ffs_pkg::*;
#(
  parameter int ONES_LEN = FFS_ONES_DEFAULT,
  parameter int REPS_MIN = FFS_REPS_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_cond,
  input  logic norm_bit,
  output logic tx_bit,
  output logic active
);
  localparam int REP_LEN = ONES_LEN + 1;
  localparam int POS_W   = $clog2(REP_LEN);
  localparam int REP_W   = $clog2(REPS_MIN + 1);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(ONES_LEN);
  localparam logic [REP_W-1:0] REP_SAT   = REP_W'(REPS_MIN);
  localparam logic [REP_W-1:0] REP_FINAL = REP_W'(REPS_MIN - 1);

  tx_mode_e           mode_q, mode_d;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [REP_W-1:0]   reps_q, reps_d;
  logic               tx_q, tx_d;

  always_comb begin
    mode_d = mode_q;
    pos_d  = pos_q;
    reps_d = reps_q;
    case (mode_q)
      TX_NORMAL: begin
        if (fault_cond) begin
          mode_d = TX_FAULT;
          pos_d  = '0;
          reps_d = '0;
        end
      end
      default: begin
        if (pos_q == LAST_POS) begin
          pos_d = '0;
          if (reps_q != REP_SAT) reps_d = reps_q + 1'b1;
          if ((reps_q >= REP_FINAL) && !fault_cond) mode_d = TX_NORMAL;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    endcase
    tx_d = (mode_d == TX_FAULT) ? (pos_d != LAST_POS) : norm_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TX_NORMAL;
      pos_q  <= '0;
      reps_q <= '0;
      tx_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pos_q  <= pos_d;
      reps_q <= reps_d;
      tx_q   <= tx_d;
    end
  end

  assign tx_bit = tx_q;
  assign active = (mode_q == TX_FAULT);

  // R3: every pattern opens with a one bit
  p_first_bit_one_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> tx_bit);
  // R4: the pattern never ends before its minimum unit count
  p_min_units_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(reps_q) >= REP_FINAL));
  // R5: the pattern ends only right after a closing zero bit
  p_end_on_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(pos_q) == LAST_POS && !$past(tx_bit)));
endmodule

// File: rtl/ffs_rx_det.sv
module ffs_rx_det
  import ffs_pkg::*;
#(
  parameter int ONES_LEN = FFS_ONES_DEFAULT,
  parameter int REPS_MIN = FFS_REPS_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic rx_bit,
  output logic remote_fault
);
  localparam int CNT_W = $clog2(ONES_LEN + 2);
  localparam int REP_W = $clog2(REPS_MIN + 1);
  localparam logic [CNT_W-1:0] RUN_FULL  = CNT_W'(ONES_LEN);
  localparam logic [CNT_W-1:0] RUN_SAT   = CNT_W'(ONES_LEN + 1);
  localparam logic [REP_W-1:0] REP_SAT   = REP_W'(REPS_MIN);
  localparam logic [REP_W-1:0] REP_FINAL = REP_W'(REPS_MIN - 1);

  logic [CNT_W-1:0] ones_q;
  logic [REP_W-1:0] reps_q;
  logic             rf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= '0;
      reps_q <= '0;
      rf_q   <= 1'b0;
    end else if (!scan_en) begin
      ones_q <= '0;
      reps_q <= '0;
      rf_q   <= 1'b0;
    end else if (rx_bit) begin
      if (ones_q != RUN_SAT) ones_q <= ones_q + 1'b1;
      if (ones_q == RUN_FULL) begin
        reps_q <= '0;
        rf_q   <= 1'b0;
      end
    end else begin
      ones_q <= '0;
      if (ones_q == RUN_FULL) begin
        if (reps_q != REP_SAT)   reps_q <= reps_q + 1'b1;
        if (reps_q >= REP_FINAL) rf_q   <= 1'b1;
      end else begin
        reps_q <= '0;
        rf_q   <= 1'b0;
      end
    end
  end

  assign remote_fault = rf_q;

  // R9: the flag rises only on a zero that closes a full run
  p_rise_on_valid_close_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_fault) |-> (!$past(rx_bit) && $past(ones_q) == RUN_FULL));
  // R10: a zero after a wrong run length drops the flag
  p_bad_close_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !rx_bit && ones_q != RUN_FULL) |=> !remote_fault);
  // R11: a blocked receiver cannot hold the flag
  p_blocked_clears_r11: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> !remote_fault);
endmodule

// File: rtl/ffs_signaler.sv
module ffs_signaler
  import ffs_pkg::*;
#(
  parameter int ONES_LEN = FFS_ONES_DEFAULT,
  parameter int REPS_MIN = FFS_REPS_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_mode,
  input  logic fault_tx_en,
  input  logic loopback,
  input  logic sig_det,
  input  logic rx_bit,
  input  logic tx_norm_bit,
  output logic tx_bit,
  output logic pattern_active,
  output logic link_fail,
  output logic remote_fault
);
  logic scan_en;
  logic fault_cond;

  assign fault_cond = fiber_mode & fault_tx_en & ~loopback & ~sig_det;

  ffs_link_mon u_link (
    .clk        (clk),
    .rst        (rst),
    .fiber_mode (fiber_mode),
    .sig_det    (sig_det),
    .scan_en    (scan_en),
    .link_fail  (link_fail)
  );

  ffs_tx_gen #(.ONES_LEN(ONES_LEN), .REPS_MIN(REPS_MIN)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .fault_cond (fault_cond),
    .norm_bit   (tx_norm_bit),
    .tx_bit     (tx_bit),
    .active     (pattern_active)
  );

  ffs_rx_det #(.ONES_LEN(ONES_LEN), .REPS_MIN(REPS_MIN)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .scan_en      (scan_en),
    .rx_bit       (rx_bit),
    .remote_fault (remote_fault)
  );

  // R2: twisted-pair mode never starts the pattern
  p_tp_stays_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!fiber_mode && !pattern_active) |=> !pattern_active);
  // R6: without the enable no pattern starts
  p_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    (!fault_tx_en && !pattern_active) |=> !pattern_active);
  // R7: loopback blocks the start of the pattern
  p_loop_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (loopback && !pattern_active) |=> !pattern_active);
endmodule

// File: tb/test_ffs_signaler.sv
module test_ffs_signaler;
  logic clk = 1'b0;
  logic rst, fiber_mode, fault_tx_en, loopback, sig_det, rx_bit, tx_norm_bit;
  logic tx_bit, pattern_active, link_fail, remote_fault;
  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ffs_signaler i_ffs_signaler (
    .clk            (clk),
    .rst            (rst),
    .fiber_mode     (fiber_mode),
    .fault_tx_en    (fault_tx_en),
    .loopback       (loopback),
    .sig_det        (sig_det),
    .rx_bit         (rx_bit),
    .tx_norm_bit    (tx_norm_bit),
    .tx_bit         (tx_bit),
    .pattern_active (pattern_active),
    .link_fail      (link_fail),
    .remote_fault   (remote_fault)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fiber_mode = 1'b1; fault_tx_en = 1'b1; loopback = 1'b0;
    sig_det = 1'b1; rx_bit = 1'b0; tx_norm_bit = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx_bit = b;
    step();
  endtask

  task automatic send_unit(input int n_ones);
    for (int k = 0; k < n_ones; k++) send_bit(1'b1);
    send_bit(1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx_bit", tx_bit, 1'b0);
    chk("R1 pattern_active", pattern_active, 1'b0);
    chk("R1 link_fail", link_fail, 1'b0);
    chk("R1 remote_fault", remote_fault, 1'b0);
    step();
    chk("R1 idle after release", pattern_active, 1'b0);
  endtask

  task automatic t_twisted_pair();
    do_reset();
    fiber_mode = 1'b0;
    sig_det = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tx_norm_bit = (i % 3 == 0);
      step();
      chk("R2 pass-through", tx_bit, (i % 3 == 0));
      chk("R2 no pattern", pattern_active, 1'b0);
      chk("R2 no link_fail", link_fail, 1'b0);
    end
    sig_det = 1'b1;
    send_bit(1'b0);
    repeat (3) send_unit(84);
    chk("R2 detector idle", remote_fault, 1'b0);
  endtask

  task automatic t_min_units();
    do_reset();
    tx_norm_bit = 1'b0;
    sig_det = 1'b0;
    for (int i = 0; i <= 255; i++) begin
      step();
      chk("R4 active window", pattern_active, (i < 255));
      if (i < 255) chk("R3 unit bits", tx_bit, (i % 85 != 84));
      if (i == 0) begin
        chk("R8 link_fail set", link_fail, 1'b1);
        sig_det = 1'b1;
      end
      if (i == 1) chk("R8 link_fail clear", link_fail, 1'b0);
    end
    chk("R4 back to normal bit", tx_bit, 1'b0);
  endtask

  task automatic t_persist();
    do_reset();
    tx_norm_bit = 1'b1;
    sig_det = 1'b0;
    for (int i = 0; i <= 345; i++) begin
      step();
      chk("R5 active until boundary", pattern_active, (i <= 339));
      if (i <= 339) chk("R5 unit bits", tx_bit, (i % 85 != 84));
      else chk("R5 normal bit after end", tx_bit, 1'b1);
      if (i == 299) sig_det = 1'b1;
    end
  endtask

  task automatic t_enable_off();
    do_reset();
    fault_tx_en = 1'b0;
    sig_det = 1'b0;
    for (int i = 0; i < 200; i++) begin
      tx_norm_bit = (i % 2 == 1);
      step();
      chk("R6 no pattern", pattern_active, 1'b0);
      chk("R6 normal bit", tx_bit, (i % 2 == 1));
    end
    chk("R8 link_fail on loss", link_fail, 1'b1);
  endtask

  task automatic t_loopback();
    do_reset();
    loopback = 1'b1;
    sig_det = 1'b0;
    for (int i = 0; i < 200; i++) begin
      step();
      chk("R7 no pattern in loopback", pattern_active, 1'b0);
    end
    loopback = 1'b0;
    step();
    chk("R7 starts after loopback clears", pattern_active, 1'b1);
    chk("R7 first bit one", tx_bit, 1'b1);
  endtask

  task automatic t_detect();
    do_reset();
    fault_tx_en = 1'b0;
    send_bit(1'b0);
    send_unit(84);
    chk("R9 one unit not enough", remote_fault, 1'b0);
    send_unit(84);
    chk("R9 two units not enough", remote_fault, 1'b0);
    for (int k = 0; k < 84; k++) send_bit(1'b1);
    chk("R9 not before closing zero", remote_fault, 1'b0);
    send_bit(1'b0);
    chk("R9 set after third unit", remote_fault, 1'b1);
    send_unit(84);
    chk("R9 held on further units", remote_fault, 1'b1);
  endtask

  task automatic t_bad_windows();
    send_unit(83);
    chk("R10 short run clears", remote_fault, 1'b0);
    send_unit(84);
    send_unit(84);
    chk("R10 count restarted", remote_fault, 1'b0);
    send_unit(84);
    chk("R10 set again", remote_fault, 1'b1);
    for (int k = 0; k < 84; k++) send_bit(1'b1);
    chk("R10 held at 84 ones", remote_fault, 1'b1);
    send_bit(1'b1);
    chk("R10 85th one clears", remote_fault, 1'b0);
    send_bit(1'b0);
    chk("R10 zero after long run", remote_fault, 1'b0);
    send_unit(84);
    send_unit(84);
    chk("R10 two after long run", remote_fault, 1'b0);
    send_unit(84);
    chk("R10 three after long run", remote_fault, 1'b1);
  endtask

  task automatic t_loss();
    sig_det = 1'b0;
    step();
    chk("R11 loss clears flag", remote_fault, 1'b0);
    send_bit(1'b0);
    repeat (3) send_unit(84);
    chk("R11 blocked while lost", remote_fault, 1'b0);
    sig_det = 1'b1;
    send_bit(1'b0);
    repeat (3) send_unit(84);
    chk("R11 works after restore", remote_fault, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; fiber_mode = 1'b0; fault_tx_en = 1'b0; loopback = 1'b0;
    sig_det = 1'b1; rx_bit = 1'b0; tx_norm_bit = 1'b0;
    t_reset();
    t_twisted_pair();
    t_min_units();
    t_persist();
    t_enable_off();
    t_loopback();
    t_detect();
    t_bad_windows();
    t_loss();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule